// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a processor a narrow window into an internal configuration RAM of 128 bytes. The processor sees three byte-wide registers on a small register bus: an address/command register, a data register and a status register. Writing the address/command register launches a single RAM operation, either a read or a write, that occupies a fixed number of clock cycles. The cycle count is derived at elaboration time from the clock period and the required operation time, so the window always covers the required duration.

While an operation is in flight the status register shows a busy flag. Software loads the data register before launching a write, and collects the result from the data register after a read has finished. A launch attempted while busy is dropped and recorded in a sticky error flag that software clears by writing a one to it. Register reads are combinational from the selected register.

Top module: `indirect_cfg_port`

## Requirements
- R1: After reset the address/command register, the data register and the status register all read 0x00.
- R2: A write to register select 0 while not busy stores the byte; bits 6..0 are the RAM index and bit 7 is the direction (1 = read, 0 = write), and the stored byte reads back unchanged on select 0.
- R3: Status bit 7 (busy) rises in the cycle after an accepted launch and stays high for exactly OP_CYCLES consecutive cycles.
- R4: OP_CYCLES equals the required operation time divided by the clock period, rounded up (490000 ps over 8000 ps gives 62).
- R5: A write operation stores the data register contents at the selected RAM index by the time busy clears.
- R6: When a read operation has finished, the data register (select 1) holds the RAM byte at the selected index.
- R7: A write to select 0 while busy is ignored: the address/command register keeps its value and the running operation ends at its original time.
- R8: The rejected launch of R7 sets status bit 0; that bit stays set until a write to select 2 with data bit 0 equal to 1, and a status write with bit 0 equal to 0 leaves it set.
- R9: A write to select 1 while busy is ignored and does not alter the value an ongoing write operation stores.
- R10: Select 3 reads 0x00 and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| regSel | input | 2 | Register select: 0 address/command, 1 data, 2 status, 3 unused |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |

## Verification
The hardest situations to reach are the collisions between the bus and an operation in flight: a second launch or a data-register write landing in the middle of the busy window. The stimulus launches an operation, waits a few cycles into the window, issues the conflicting write, and then measures the full busy length and the stored or returned bytes to show the operation was untouched. Around this, a sweep writes a computed byte pattern to every one of the 128 indices and reads each back through the same window.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic acceptOp;
    logic finish;
    logic loadData;
  } strobe_t;
endpackage

// File: rtl/irp_ctrl.sv
module irp_ctrl
  import irp_pkg::*;
#(
  parameter int OP_CYCLES = 62
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regSel,
  input  logic       errClrBit,
  output strobe_t    strb,
  output logic       busy,
  output logic       errFlag
);
  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic addrHit, statHit, dataHit;

  assign addrHit = wrEn && (regSel == SEL_ADDR);
  assign dataHit = wrEn && (regSel == SEL_DATA);
  assign statHit = wrEn && (regSel == SEL_STAT);

  always_comb begin
    strb.acceptOp = addrHit && !busy;
    strb.finish   = busy && (cnt == '0);
    strb.loadData = dataHit && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strb.acceptOp) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     errFlag <= 1'b0;
    else if (addrHit && busy)      errFlag <= 1'b1;
    else if (statHit && errClrBit) errFlag <= 1'b0;
  end

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && !busy) |=> busy);
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == '0) |=> !busy);
  // R8
  reject_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && busy) |=> errFlag);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(statHit && errClrBit)) |=> errFlag);
  // R7
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/irp_datapath.sv
module irp_datapath
  import irp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic              errFlag,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] cfgRam [DEPTH];
  logic [ADDR_W-1:0] ramIdx;
  logic              opRead;

  assign ramIdx = addrReg[ADDR_W-1:0];
  assign opRead = addrReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrReg <= '0;
    else if (strb.acceptOp) addrReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        dataReg <= '0;
    else if (strb.finish && opRead)   dataReg <= cfgRam[ramIdx];
    else if (strb.loadData)           dataReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strb.finish && !opRead) cfgRam[ramIdx] <= dataReg;
  end

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_ADDR: rdData = addrReg;
      SEL_DATA: rdData = dataReg;
      SEL_STAT: rdData = {busy, {(DATA_W-2){1'b0}}, errFlag};
      default:  rdData = '0;
    endcase
  end

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrReg) || !$past(busy));
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> $stable(dataReg));
  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !strb.acceptOp) |=> $stable(addrReg));
endmodule

// File: rtl/indirect_cfg_port.sv
module indirect_cfg_port
  import irp_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int OP_TIME_PS    = 490000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  // R4: round the operation time up to whole clock cycles
  localparam int OP_CYCLES = (OP_TIME_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  strobe_t strb;
  logic    busy;
  logic    errFlag;

  irp_ctrl #(.OP_CYCLES(OP_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .regSel    (regSel),
    .errClrBit (wrData[0]),
    .strb      (strb),
    .busy      (busy),
    .errFlag   (errFlag)
  );

  irp_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busy    (busy),
    .errFlag (errFlag),
    .regSel  (regSel),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  // R4
  cycles_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (OP_CYCLES * CLK_PERIOD_PS >= OP_TIME_PS) && (OP_CYCLES >= 1));
endmodule

// File: tb/indirect_cfg_port_tb.sv
module indirect_cfg_port_tb;
  localparam int PERIOD_PS = 8000;
  localparam int OPTIME_PS = 490000;
  localparam int EXP_CYC   = (OPTIME_PS + PERIOD_PS - 1) / PERIOD_PS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4ns clk = ~clk;

  indirect_cfg_port #(.CLK_PERIOD_PS(PERIOD_PS), .OP_TIME_PS(OPTIME_PS)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1ns;
    val = rdData;
  endtask

  // count cycles with busy high, starting at the negedge just after launch
  task automatic measureBusy(output int n);
    logic [7:0] s;
    n = 0;
    regRead(2'd2, s);
    while (s[7] && n < 1000) begin
      n++;
      @(negedge clk);
      regRead(2'd2, s);
    end
  endtask

  task automatic waitIdle();
    int n;
    measureBusy(n);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      regRead(2'(s), v);
      check("R1", v, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3/R4/R5 sweep: write pattern to every index, measuring busy
    for (int a = 0; a < 128; a++) begin
      regWrite(2'd1, pat(a));
      regWrite(2'd0, 8'(a));
      measureBusy(n);
      if (a < 4) check("R3 R4 busy length", n, EXP_CYC);
      if (a == 5) begin
        regRead(2'd0, v);
        check("R2 addr readback", v, a);
      end
    end
    // R6 read-back sweep
    for (int a = 0; a < 128; a++) begin
      regWrite(2'd0, 8'(8'h80 | a));
      measureBusy(n);
      if (a == 127) check("R3 busy length read", n, EXP_CYC);
      regRead(2'd1, v);
      check("R5 R6 readback", v, pat(a));
      if (a == 127) begin
        regRead(2'd0, v);
        check("R2 dir bit readback", v, 8'hFF);
      end
    end

    // R7/R8 launch while busy
    regWrite(2'd0, 8'h80 | 8'd10);      // read index 10
    repeat (5) @(negedge clk);
    regWrite(2'd0, 8'h00 | 8'd20);      // rejected
    regRead(2'd0, v);
    check("R7 addr kept", v, 8'h8A);
    measureBusy(n);
    check("R7 original end time", n, EXP_CYC - 7);
    regRead(2'd1, v);
    check("R7 read result", v, pat(10));
    regRead(2'd2, v);
    check("R8 error set", v, 8'h01);
    regWrite(2'd2, 8'hFE);
    regRead(2'd2, v);
    check("R8 clear needs bit0", v, 8'h01);
    regWrite(2'd2, 8'h01);
    regRead(2'd2, v);
    check("R8 cleared", v, 8'h00);

    // R9 data write while busy
    regWrite(2'd1, 8'h5A);
    regWrite(2'd0, 8'd30);              // write 0x5A to index 30
    repeat (3) @(negedge clk);
    regWrite(2'd1, 8'hC3);              // ignored
    regRead(2'd1, v);
    check("R9 data held", v, 8'h5A);
    waitIdle();
    regWrite(2'd0, 8'h80 | 8'd30);
    waitIdle();
    regRead(2'd1, v);
    check("R9 stored value", v, 8'h5A);
    regRead(2'd2, v);
    check("R9 no error", v, 8'h00);

    // R10 unused select
    regWrite(2'd3, 8'hFF);
    regRead(2'd3, v);
    check("R10 reads zero", v, 0);
    regRead(2'd0, v);
    check("R10 addr untouched", v, 8'h9E);
    regRead(2'd1, v);
    check("R10 data untouched", v, 8'h5A);
    regRead(2'd2, v);
    check("R10 status untouched", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule